// File: doc/BRIEF.md
# MMU Fault Syndrome Generator

This block sits between a page-translation lookup and the processor's exception logic. Each cycle it may receive one translation request. A request carries a virtual address, an access kind (instruction fetch, data load or data store), a probe flag and the current MMU-enable state. It also carries the result of the lookup: hit flag, physical base, matched virtual base, permission bits and error kind. One cycle later it returns the physical address and permissions. With the MMU off the address passes straight through at page granularity with every permission granted.

When a non-probe request misses, the block builds an exception syndrome. The syndrome code depends on the error kind and on fetch versus data access, and one separate bit marks stores. The full faulting address is latched. A single-cycle fault request is raised and a pending flag is set, which stays set until the exception logic returns `fault_clear`. A second fault that arrives while one is pending is not accepted; the block pulses a recursive-fault error instead. An error kind the block does not know pulses an internal-error output. The translation table and the exception entry sequence are outside this block.

Top module: `mflt_syndrome`

## Requirements
- R1: While reset is asserted and after it, before any request, every output is zero, including `ear`, `esr` and `fault_pending`.
- R2: With `mmu_on` low, a valid request returns on the next cycle `rsp_valid`=1, `rsp_hit`=1, `rsp_paddr` = `req_vaddr` with its low PAGE_BITS bits cleared, and `rsp_perm` all ones. It never faults. A cycle without `req_valid` returns all response outputs zero on the next cycle.
- R3: With `mmu_on` high and `lu_hit` high, the next cycle gives `rsp_hit`=1, `rsp_paddr` = `lu_pbase` + page-aligned `req_vaddr` − `lu_vbase` (modulo 2^AW), and `rsp_perm` = `lu_prot`. `lu_err` is ignored.
- R4: `lu_err` encoding: 1 = protection, 2 = miss. An accepted protection fault gives an `esr` low field of 17 for a fetch and 16 for a data access.
- R5: An accepted miss fault gives an `esr` low field of 19 for a fetch and 18 for a data access.
- R6: `req_acc` encoding: 0 = fetch, 1 = load, 2 = store, 3 = load. Bit 10 of `esr` is set only when the faulting access is a store. All other bits above bit 4 are zero.
- R7: A non-probe miss (`mmu_on`=1, `lu_hit`=0) that is accepted raises `fault_req` for exactly one cycle, on the cycle after the request. In that same cycle `ear` holds the full `req_vaddr`. `ear` and `esr` change in no other cycle.
- R8: A probe request that misses returns `rsp_valid`=1 with `rsp_hit`=0. It raises none of the three event outputs and leaves `ear`, `esr` and `fault_pending` unchanged.
- R9: A known-kind non-probe miss while a fault is pending pulses `recursive_err` for one cycle instead of `fault_req`, and leaves `ear` and `esr` unchanged.
- R10: `fault_pending` rises together with `fault_req` and falls one cycle after `fault_clear`. A `fault_clear` in the same cycle as a new miss frees the slot, so the new fault is accepted.
- R11: A non-probe miss whose `lu_err` is 0 or 3 pulses `internal_err`. It raises no fault, does not touch `ear` or `esr`, and takes priority over the recursive check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | AW | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| req_probe | input | 1 | Probe: a miss fails silently |
| mmu_on | input | 1 | Translation enabled |
| lu_hit | input | 1 | Lookup found an entry |
| lu_pbase | input | AW | Physical base of the matched entry |
| lu_vbase | input | AW | Virtual base of the matched entry |
| lu_err | input | 2 | Error kind on miss: 1 protection, 2 miss |
| lu_prot | input | PERM_W | Permissions of the matched entry |
| fault_clear | input | 1 | Exception logic releases the pending fault |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | AW | Physical address |
| rsp_perm | output | PERM_W | Granted permissions |
| fault_req | output | 1 | One-cycle fault raise |
| recursive_err | output | 1 | Fault arrived while one was pending |
| internal_err | output | 1 | Unknown error kind on a miss |
| fault_pending | output | 1 | A fault awaits clearing |
| ear | output | AW | Latched faulting address |
| esr | output | ESR_W | Latched syndrome code |

## Verification
The translation path is tried with the MMU off and with hits whose bases force the address sum to wrap past zero. This separates plain masking from the base arithmetic. Misses are tried with every combination of error kind and access kind, so that the four code values and the store bit each stand apart. Event ordering is tested with a miss while a fault is pending, with a clear alone, and with a clear in the same cycle as a miss, which shows whether the clear is given priority. Probe misses and unknown error kinds are sent while `ear` and `esr` already hold distinct values, so that any unwanted write to them can be seen.

// File: rtl/mflt_pkg.sv
package mflt_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      LKERR_NONE = 2'd0,
      LKERR_PROT = 2'd1,
      LKERR_MISS = 2'd2,
      LKERR_RSVD = 2'd3
   } lk_err_e;

   // syndrome low-field values for data accesses; a fetch adds one
   localparam logic [4:0] CODE_PROT_DATA = 5'd16;
   localparam logic [4:0] CODE_MISS_DATA = 5'd18;
   localparam int unsigned CODE_FIELD_W  = 5;

endpackage

// File: rtl/mflt_xlate.sv
module mflt_xlate
   import mflt_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned PERM_W    = 3
) (
   input  logic              mmu_on,
   input  logic [AW-1:0]     vaddr,
   input  logic              lu_hit,
   input  logic [AW-1:0]     lu_pbase,
   input  logic [AW-1:0]     lu_vbase,
   input  logic [PERM_W-1:0] lu_prot,
   output logic              hit,
   output logic [AW-1:0]     paddr,
   output logic [PERM_W-1:0] perm
);

   logic [AW-1:0] page_mask;
   logic [AW-1:0] va_page;

   // mask keeps the bits above the page offset
   for (genvar g = 0; g < AW; g++) begin : g_mask
      if (g < PAGE_BITS) begin : g_off
         assign page_mask[g] = 1'b0;
      end else begin : g_page
         assign page_mask[g] = 1'b1;
      end
   end

   assign va_page = vaddr & page_mask;

   always_comb begin
      hit   = 1'b0;
      paddr = '0;
      perm  = '0;
      if (!mmu_on) begin
         hit   = 1'b1;
         paddr = va_page;
         perm  = '1;
      end else if (lu_hit) begin
         hit   = 1'b1;
         paddr = lu_pbase + va_page - lu_vbase;
         perm  = lu_prot;
      end
   end

endmodule

// File: rtl/mflt_code.sv
module mflt_code
   import mflt_pkg::*;
#(
   parameter int unsigned ESR_W     = 32,
   parameter int unsigned STORE_POS = 10
) (
   input  acc_kind_e         acc,
   input  lk_err_e           err,
   output logic              known,
   output logic [ESR_W-1:0]  code
);

   logic [CODE_FIELD_W-1:0] field;

   always_comb begin
      known = (err == LKERR_PROT) || (err == LKERR_MISS);
      field = (err == LKERR_MISS) ? CODE_MISS_DATA : CODE_PROT_DATA;
      if (acc == ACC_FETCH) begin
         field = field + 5'd1;
      end
      code                     = '0;
      code[CODE_FIELD_W-1:0]   = field;
      code[STORE_POS]          = (acc == ACC_STORE);
   end

endmodule

// File: rtl/mflt_track.sv
module mflt_track #(
   parameter int unsigned AW    = 32,
   parameter int unsigned ESR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_ev,
   input  logic             known,
   input  logic [ESR_W-1:0] code,
   input  logic [AW-1:0]    vaddr,
   input  logic             clear,
   output logic             fault_req,
   output logic             recursive_err,
   output logic             internal_err,
   output logic             pending,
   output logic [AW-1:0]    ear,
   output logic [ESR_W-1:0] esr
);

   logic slot_busy;
   logic take_bad;
   logic take_recur;
   logic take_fault;

   // a clear in the same cycle frees the slot before the new miss is judged
   assign slot_busy  = pending & ~clear;
   assign take_bad   = miss_ev & ~known;
   assign take_recur = miss_ev & known & slot_busy;
   assign take_fault = miss_ev & known & ~slot_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_req     <= 1'b0;
         recursive_err <= 1'b0;
         internal_err  <= 1'b0;
         pending       <= 1'b0;
         ear           <= '0;
         esr           <= '0;
      end else begin
         fault_req     <= take_fault;
         recursive_err <= take_recur;
         internal_err  <= take_bad;
         pending       <= slot_busy | take_fault;
         if (take_fault) begin
            ear <= vaddr;
            esr <= code;
         end
      end
   end

endmodule

// File: rtl/mflt_syndrome.sv
module mflt_syndrome
   import mflt_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned PERM_W    = 3,
   parameter int unsigned ESR_W     = 32,
   parameter int unsigned STORE_POS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [AW-1:0]     req_vaddr,
   input  logic [1:0]        req_acc,
   input  logic              req_probe,
   input  logic              mmu_on,
   input  logic              lu_hit,
   input  logic [AW-1:0]     lu_pbase,
   input  logic [AW-1:0]     lu_vbase,
   input  logic [1:0]        lu_err,
   input  logic [PERM_W-1:0] lu_prot,
   input  logic              fault_clear,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [AW-1:0]     rsp_paddr,
   output logic [PERM_W-1:0] rsp_perm,
   output logic              fault_req,
   output logic              recursive_err,
   output logic              internal_err,
   output logic              fault_pending,
   output logic [AW-1:0]     ear,
   output logic [ESR_W-1:0]  esr
);

   if (PAGE_BITS >= AW) begin : g_bad_page
      $error("PAGE_BITS must be below AW");
   end
   if (ESR_W <= STORE_POS || STORE_POS < CODE_FIELD_W) begin : g_bad_esr
      $error("store bit must lie inside ESR_W and above the code field");
   end
   if (PERM_W == 0) begin : g_bad_perm
      $error("PERM_W must be at least one");
   end

   logic              x_hit;
   logic [AW-1:0]     x_paddr;
   logic [PERM_W-1:0] x_perm;
   logic              c_known;
   logic [ESR_W-1:0]  c_code;
   logic              miss_ev;

   mflt_xlate #(
      .AW(AW), .PAGE_BITS(PAGE_BITS), .PERM_W(PERM_W)
   ) i_xlate (
      .mmu_on   (mmu_on),
      .vaddr    (req_vaddr),
      .lu_hit   (lu_hit),
      .lu_pbase (lu_pbase),
      .lu_vbase (lu_vbase),
      .lu_prot  (lu_prot),
      .hit      (x_hit),
      .paddr    (x_paddr),
      .perm     (x_perm)
   );

   mflt_code #(
      .ESR_W(ESR_W), .STORE_POS(STORE_POS)
   ) i_code (
      .acc   (acc_kind_e'(req_acc)),
      .err   (lk_err_e'(lu_err)),
      .known (c_known),
      .code  (c_code)
   );

   assign miss_ev = req_valid & ~x_hit & ~req_probe;

   mflt_track #(
      .AW(AW), .ESR_W(ESR_W)
   ) i_track (
      .clk           (clk),
      .rst_n         (rst_n),
      .miss_ev       (miss_ev),
      .known         (c_known),
      .code          (c_code),
      .vaddr         (req_vaddr),
      .clear         (fault_clear),
      .fault_req     (fault_req),
      .recursive_err (recursive_err),
      .internal_err  (internal_err),
      .pending       (fault_pending),
      .ear           (ear),
      .esr           (esr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_paddr <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid & x_hit;
         rsp_paddr <= req_valid ? x_paddr : '0;
         rsp_perm  <= req_valid ? x_perm  : '0;
      end
   end

endmodule

// File: rtl/mflt_syndrome_chk.sv
module mflt_syndrome_chk #(
   parameter int unsigned AW        = 32,
   parameter int unsigned PERM_W    = 3,
   parameter int unsigned ESR_W     = 32,
   parameter int unsigned STORE_POS = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_probe,
   input logic              mmu_on,
   input logic              rsp_hit,
   input logic [PERM_W-1:0] rsp_perm,
   input logic              fault_req,
   input logic              recursive_err,
   input logic              internal_err,
   input logic              fault_pending,
   input logic [AW-1:0]     ear,
   input logic [ESR_W-1:0]  esr
);

   logic [ESR_W-1:0] esr_low;

   always_comb begin
      esr_low            = esr;
      esr_low[STORE_POS] = 1'b0;
   end

   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault_req, recursive_err, internal_err})); // R9

   AST_SYNDROME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_req |-> ($stable(esr) && $stable(ear))); // R7

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_req |-> (esr_low >= 16 && esr_low <= 19)); // R5

   AST_PEND_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      fault_req |-> fault_pending); // R10

   AST_RECUR_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      recursive_err |-> $past(fault_pending)); // R9

   AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_probe) |-> !(fault_req || recursive_err || internal_err)); // R8

   AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && !mmu_on) |-> (rsp_hit && (&rsp_perm))); // R2

endmodule

bind mflt_syndrome mflt_syndrome_chk #(
   .AW(AW), .PERM_W(PERM_W), .ESR_W(ESR_W), .STORE_POS(STORE_POS)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_probe     (req_probe),
   .mmu_on        (mmu_on),
   .rsp_hit       (rsp_hit),
   .rsp_perm      (rsp_perm),
   .fault_req     (fault_req),
   .recursive_err (recursive_err),
   .internal_err  (internal_err),
   .fault_pending (fault_pending),
   .ear           (ear),
   .esr           (esr)
);

// File: tb/test_mflt_syndrome.sv
module test_mflt_syndrome;

   localparam int CLK_PERIOD = 10;
   localparam int PB         = 12;
   localparam logic [31:0] PMASK = ~((32'd1 << PB) - 32'd1);

   typedef struct {
      logic        rv;
      logic        rh;
      logic [31:0] pa;
      logic [2:0]  pm;
      logic        fr;
      logic        re;
      logic        ie;
      logic        pd;
      logic [31:0] ea;
      logic [31:0] es;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_probe, mmu_on, lu_hit, fault_clear;
   logic [31:0] req_vaddr, lu_pbase, lu_vbase;
   logic [1:0]  req_acc, lu_err;
   logic [2:0]  lu_prot;
   logic        rsp_valid, rsp_hit, fault_req, recursive_err, internal_err, fault_pending;
   logic [31:0] rsp_paddr, ear, esr;
   logic [2:0]  rsp_perm;

   int n_cmp = 0;
   int n_bad = 0;
   exp_t exp_q[$];

   logic        m_pend = 1'b0;
   logic [31:0] m_ear  = '0;
   logic [31:0] m_esr  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mflt_syndrome i_mflt_syndrome (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .req_probe(req_probe), .mmu_on(mmu_on), .lu_hit(lu_hit),
      .lu_pbase(lu_pbase), .lu_vbase(lu_vbase), .lu_err(lu_err), .lu_prot(lu_prot),
      .fault_clear(fault_clear), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .fault_req(fault_req),
      .recursive_err(recursive_err), .internal_err(internal_err),
      .fault_pending(fault_pending), .ear(ear), .esr(esr)
   );

   task automatic drive(input logic v, input logic [31:0] va, input logic [1:0] acc,
                        input logic pr, input logic mo, input logic lh,
                        input logic [31:0] pb, input logic [31:0] vb,
                        input logic [1:0] er, input logic [2:0] pt,
                        input logic clr, input string tag);
      exp_t e;
      logic miss, busy;
      @(negedge clk);
      req_valid = v; req_vaddr = va; req_acc = acc; req_probe = pr; mmu_on = mo;
      lu_hit = lh; lu_pbase = pb; lu_vbase = vb; lu_err = er; lu_prot = pt;
      fault_clear = clr;
      e.rv = v; e.rh = 1'b0; e.pa = '0; e.pm = '0;
      e.fr = 1'b0; e.re = 1'b0; e.ie = 1'b0; e.tag = tag;
      if (v && !mo) begin
         e.rh = 1'b1; e.pa = va & PMASK; e.pm = 3'b111;
      end else if (v && lh) begin
         e.rh = 1'b1; e.pa = pb + (va & PMASK) - vb; e.pm = pt;
      end
      miss = v && mo && !lh && !pr;
      busy = m_pend && !clr;
      if (miss) begin
         if (er != 2'd1 && er != 2'd2) e.ie = 1'b1;
         else if (busy) e.re = 1'b1;
         else begin
            e.fr  = 1'b1;
            m_ear = va;
            m_esr = (er == 2'd1) ? 32'd16 : 32'd18;
            if (acc == 2'd0) m_esr = m_esr + 32'd1;
            if (acc == 2'd2) m_esr = m_esr | 32'd1024;
         end
      end
      m_pend = busy || e.fr;
      e.pd = m_pend; e.ea = m_ear; e.es = m_esr;
      exp_q.push_back(e);
   endtask

   task automatic idle(input logic clr, input string tag);
      drive(1'b0, '0, 2'd0, 1'b0, 1'b1, 1'b0, '0, '0, 2'd0, 3'd0, clr, tag);
   endtask

   task automatic miss(input logic [31:0] va, input logic [1:0] acc, input logic pr,
                       input logic [1:0] er, input logic clr, input string tag);
      drive(1'b1, va, acc, pr, 1'b1, 1'b0, 32'h5555_0000, 32'h1111_0000, er, 3'd6, clr, tag);
   endtask

   // monitor: compare one expected item per cycle after the edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (rsp_valid !== e.rv || rsp_hit !== e.rh || rsp_paddr !== e.pa ||
             rsp_perm !== e.pm || fault_req !== e.fr || recursive_err !== e.re ||
             internal_err !== e.ie || fault_pending !== e.pd || ear !== e.ea || esr !== e.es) begin
            n_bad++;
            $display("FAIL %s: got v=%b h=%b pa=%h pm=%b f=%b r=%b i=%b p=%b ear=%h esr=%h | exp v=%b h=%b pa=%h pm=%b f=%b r=%b i=%b p=%b ear=%h esr=%h",
                     e.tag, rsp_valid, rsp_hit, rsp_paddr, rsp_perm, fault_req, recursive_err,
                     internal_err, fault_pending, ear, esr, e.rv, e.rh, e.pa, e.pm, e.fr,
                     e.re, e.ie, e.pd, e.ea, e.es);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      n_bad++;
      $display("FAIL watchdog: got run still active, exp finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 0; req_vaddr = '0; req_acc = '0; req_probe = 0;
      mmu_on = 0; lu_hit = 0; lu_pbase = '0; lu_vbase = '0; lu_err = '0;
      lu_prot = '0; fault_clear = 0;
      repeat (3) @(posedge clk);
      #1;
      n_cmp++;
      if ({rsp_valid, rsp_hit, rsp_paddr, rsp_perm, fault_req, recursive_err,
           internal_err, fault_pending, ear, esr} !== '0) begin
         n_bad++;
         $display("FAIL R1: got nonzero outputs in reset (ear=%h esr=%h), exp all zero", ear, esr);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle(1'b0, "R1 idle after reset");
      // R2 passthrough with MMU off, error inputs ignored
      drive(1, 32'h1234_5ABC, 2'd1, 0, 0, 0, '0, '0, 2'd2, 3'd0, 0, "R2 off load");
      drive(1, 32'hFFFF_FFFF, 2'd2, 0, 0, 0, '0, '0, 2'd3, 3'd0, 0, "R2 off store");
      idle(1'b0, "R2 idle zero");
      // R3 hit arithmetic
      drive(1, 32'h0040_1FFF, 2'd0, 0, 1, 1, 32'h8000_0000, 32'h0040_0000, 2'd2, 3'd5, 0, "R3 hit");
      drive(1, 32'h0000_1010, 2'd1, 0, 1, 1, 32'h0000_0000, 32'h0000_2000, 2'd0, 3'd2, 0, "R3 hit wrap");
      drive(1, 32'h7000_3000, 2'd2, 1, 1, 1, 32'h0001_0000, 32'h7000_0000, 2'd1, 3'd1, 0, "R3 probe hit");
      // R8 probe miss is silent
      miss(32'hDEAD_0001, 2'd2, 1, 2'd2, 0, "R8 probe miss");
      miss(32'hDEAD_0002, 2'd0, 1, 2'd3, 0, "R8 probe bad err");
      // R4 fetch protection
      miss(32'hA000_0123, 2'd0, 0, 2'd1, 0, "R4 fetch prot R7");
      // R9 recursive
      miss(32'hB000_0456, 2'd1, 0, 2'd2, 0, "R9 recursive");
      drive(1, 32'h0000_5000, 2'd1, 0, 1, 1, 32'h0000_9000, 32'h0000_5000, 2'd0, 3'd4, 0, "R3 hit while pending");
      miss(32'hC000_0001, 2'd2, 1, 2'd2, 0, "R8 probe while pending");
      // R11 bad kind while pending has priority over recursive
      miss(32'hC000_0002, 2'd1, 0, 2'd0, 0, "R11 bad err pending");
      // R10 clear alone
      idle(1'b1, "R10 clear");
      // R5 R6 store miss
      miss(32'hC0DE_0FF8, 2'd2, 0, 2'd2, 0, "R5 R6 store miss");
      // R10 same-cycle clear and new fault
      miss(32'h0BAD_F00D, 2'd2, 0, 2'd1, 1, "R10 clear+fault R6 store prot");
      idle(1'b1, "R10 clear");
      miss(32'h1357_9BDF, 2'd1, 0, 2'd1, 0, "R4 load prot");
      idle(1'b1, "R10 clear");
      miss(32'h2468_ACE0, 2'd0, 0, 2'd2, 0, "R5 fetch miss");
      idle(1'b1, "R10 clear");
      miss(32'h3333_3333, 2'd3, 0, 2'd2, 0, "R6 acc3 miss no store bit");
      idle(1'b1, "R10 clear");
      miss(32'h4444_4444, 2'd1, 0, 2'd3, 0, "R11 err3");
      miss(32'h5555_5555, 2'd2, 0, 2'd0, 0, "R11 err0");
      idle(1'b0, "R7 hold");
      idle(1'b0, "R7 hold");
      while (exp_q.size() > 0) @(posedge clk);
      @(posedge clk);
      #2;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule